// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Flags

This block is the receive-side character store of one serial channel. The receive shifter hands it each completed character. Three line-error flags come with every character: break, framing and parity. The block keeps the character and its flags together in a 64-entry first-in first-out queue. A processor drains the queue through two read strobes. A holding read removes the oldest character. A status read only samples a status word. The status word shows the flags of the oldest character, a sticky flag that is set while any stored character is erroneous, an overrun flag and a data-ready flag.

The block also produces a trigger indication and a DMA receive-ready output. The trigger indication compares the fill level with one of four selectable levels. The DMA receive-ready output has two modes: a single-character mode and a block mode that holds its state. With the queue disabled, the block behaves as a single holding location whose contents are overwritten. A one-cycle flush strobe empties the store, as does any change of the enable input. The receive timeout is computed elsewhere and arrives as an input.

Top module: `rx_char_queue`

## Requirements
- R1: Characters leave in arrival order, up to 64 stored. `rd_data` always shows the byte of the oldest stored entry and reads 0x00 when the queue is empty. A pulse on `hold_rd` removes that entry. A pulse on `hold_rd` while the queue is empty has no effect.
- R2: `status[0]` (data ready) is 1 exactly when at least one entry is stored. `status[6:5]` always read 0.
- R3: `status[4]`, `status[3]` and `status[2]` show the break, framing and parity flags of the oldest entry. All three read 0 when the queue is empty. Data and flags are stored unchanged, so a break character of 0x00 keeps its break flag.
- R4: `status[7]` is 1 while any stored entry has at least one error flag set. It returns to 0 on the cycle after the last such entry is removed.
- R5: A pulse on `stat_rd` never removes an entry and never changes the stored contents.
- R6: In queue mode, a character is discarded if it arrives while 64 entries are stored and no holding read happens in the same cycle. That event sets `status[1]` (overrun). `status[1]` then stays at 1 until a cycle with `stat_rd` high. If a new overrun and a status read fall in the same cycle, the flag stays 1.
- R7: With `q_en` low, only one location is used. Each arriving character replaces the stored one. Replacing an unread character sets `status[1]`. A character that arrives in the same cycle as a holding read replaces the old one without setting the flag.
- R8: A `flush` pulse, or a cycle in which `q_en` differs from its value in the previous cycle, empties the store and clears `status[7]`. A character arriving in that cycle is dropped. `status[1]` is left as it was.
- R9: `trig_hit` is 1 when `q_en` is high and the fill count is at least the selected level. `trig_lvl` 0, 1, 2 and 3 select 8, 16, 56 and 60.
- R10: With `q_en` high and `dma_blk` high, `dma_rx_rdy` follows a held state that is updated on every clock. The state is cleared if the queue was empty or `status[7]` was set. Otherwise it is set if the count had reached the selected level or `rx_tmo` was high. Otherwise it keeps its value.
- R11: With `dma_blk` low or `q_en` low, `dma_rx_rdy` is 1 exactly when at least one entry is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_en | input | 1 | 1 selects queue mode; 0 selects the single holding location |
| dma_blk | input | 1 | 1 selects the block DMA ready behaviour |
| trig_lvl | input | 2 | Trigger level select (8/16/56/60) |
| flush | input | 1 | One-cycle strobe that empties the store |
| rx_tmo | input | 1 | Receive timeout indication from the timeout counter |
| chr_vld | input | 1 | A character from the shifter is present this cycle |
| chr_data | input | 8 | Character byte |
| chr_brk | input | 1 | Break flag of the character |
| chr_frm | input | 1 | Framing error flag of the character |
| chr_par | input | 1 | Parity error flag of the character |
| hold_rd | input | 1 | Holding read strobe; removes the oldest entry |
| stat_rd | input | 1 | Status read strobe; clears the overrun flag |
| rd_data | output | 8 | Byte of the oldest entry |
| status | output | 8 | Status word: [7] error anywhere, [4:2] oldest entry's break/framing/parity, [1] overrun, [0] data ready |
| trig_hit | output | 1 | Fill count has reached the selected level |
| dma_rx_rdy | output | 1 | DMA receive ready, active high |

## Verification
Every strobe takes effect at the clock edge on which it is sampled. `rd_data`, `status`, `trig_hit` and the single-character form of `dma_rx_rdy` therefore change directly after that edge. The bench drives each strobe for one cycle from its negative edge and compares all outputs at the next negative edge against a queue-based model. The block-mode ready takes one more register stage: it reflects the fill count and error state from before the edge. The model follows this by computing its next ready value from the state it held before applying the cycle's push and pop.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_entry_t;

    function automatic logic entry_bad(input rx_entry_t e);
        return e.brk | e.frm | e.par;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      en,
    input  logic      push,
    input  rx_entry_t push_ent,
    input  logic      pop,
    output rx_entry_t head,
    output logic [CW-1:0] count,
    output logic      pushed,
    output logic      popped,
    output logic      dropped,
    output logic      overwrote
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t       s_d, s_q;
    rx_entry_t mem [DEPTH];
    logic      has_pop;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d       = s_q;
        pushed    = 1'b0;
        popped    = 1'b0;
        dropped   = 1'b0;
        overwrote = 1'b0;
        has_pop   = pop && (s_q.cnt != '0);
        if (clr) begin
            s_d = '0;
        end else if (en) begin
            popped  = has_pop;
            pushed  = push && ((s_q.cnt != CW'(DEPTH)) || has_pop);
            dropped = push && !pushed;
            if (pushed)  s_d.wp = step_ptr(s_q.wp);
            if (has_pop) s_d.rp = step_ptr(s_q.rp);
            s_d.cnt = s_q.cnt + CW'(pushed) - CW'(has_pop);
        end else begin
            popped    = has_pop;
            pushed    = push;
            overwrote = push && (s_q.cnt != '0) && !has_pop;
            if (push)         s_d.cnt = CW'(1);
            else if (has_pop) s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (pushed) mem[s_q.wp] <= push_ent;
    end

    assign head  = mem[s_q.rp];
    assign count = s_q.cnt;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH)); // R1

    AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> s_q.cnt <= CW'(1)); // R7

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> s_q.cnt == '0); // R8

endmodule

// File: rtl/rxq_errtrack.sv
module rxq_errtrack #(
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          pushed,
    input  logic          push_bad,
    input  logic          popped,
    input  logic          overwrote,
    input  logic          head_bad,
    input  logic          ovr_set,
    input  logic          stat_rd,
    input  logic [CW-1:0] count,
    output logic          err_any,
    output logic          overrun
);

    typedef struct packed {
        logic [CW-1:0] bad_cnt;
        logic          ovr;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.bad_cnt = '0;
        end else begin
            s_d.bad_cnt = s_q.bad_cnt
                        + CW'(pushed && push_bad)
                        - CW'((popped || overwrote) && head_bad);
        end
        if (ovr_set)      s_d.ovr = 1'b1;
        else if (stat_rd) s_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign err_any = (s_q.bad_cnt != '0);
    assign overrun = s_q.ovr;

    AST_BAD_WITHIN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bad_cnt <= count); // R4

    AST_OVR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> overrun); // R6

    AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !stat_rd |=> overrun); // R6

endmodule

// File: rtl/rxq_dmaready.sv
module rxq_dmaready #(
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] level,
    input  logic          err_any,
    input  logic          tmo,
    output logic          rdy
);

    typedef struct packed {
        logic held;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if ((count == '0) || err_any)      s_d.held = 1'b0;
        else if ((count >= level) || tmo)  s_d.held = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdy = s_q.held;

    AST_EMPTY_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |=> !rdy); // R10

    AST_ERROR_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |=> !rdy); // R10

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
    import rxq_pkg::*;
#(
    parameter  int DEPTH  = 64,
    parameter  int TRIG_0 = 8,
    parameter  int TRIG_1 = 16,
    parameter  int TRIG_2 = 56,
    parameter  int TRIG_3 = 60,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       q_en,
    input  logic       dma_blk,
    input  logic [1:0] trig_lvl,
    input  logic       flush,
    input  logic       rx_tmo,
    input  logic       chr_vld,
    input  logic [7:0] chr_data,
    input  logic       chr_brk,
    input  logic       chr_frm,
    input  logic       chr_par,
    input  logic       hold_rd,
    input  logic       stat_rd,
    output logic [7:0] rd_data,
    output logic [7:0] status,
    output logic       trig_hit,
    output logic       dma_rx_rdy
);

    typedef struct packed {
        logic en;
    } st_t;

    st_t           s_d, s_q;
    logic          clr;
    rx_entry_t     in_ent, head;
    logic [CW-1:0] count, level;
    logic          pushed, popped, dropped, overwrote;
    logic          err_any, overrun, blk_rdy, nonempty;

    always_comb begin
        s_d    = s_q;
        s_d.en = q_en;
        clr    = flush || (q_en != s_q.en);
        in_ent = '{brk: chr_brk, frm: chr_frm, par: chr_par, data: chr_data};
        unique case (trig_lvl)
            2'd0:    level = CW'(TRIG_0);
            2'd1:    level = CW'(TRIG_1);
            2'd2:    level = CW'(TRIG_2);
            default: level = CW'(TRIG_3);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .en        (s_q.en),
        .push      (chr_vld),
        .push_ent  (in_ent),
        .pop       (hold_rd),
        .head      (head),
        .count     (count),
        .pushed    (pushed),
        .popped    (popped),
        .dropped   (dropped),
        .overwrote (overwrote)
    );

    rxq_errtrack #(.DEPTH(DEPTH)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .pushed    (pushed),
        .push_bad  (entry_bad(in_ent)),
        .popped    (popped),
        .overwrote (overwrote),
        .head_bad  (entry_bad(head)),
        .ovr_set   (dropped || overwrote),
        .stat_rd   (stat_rd),
        .count     (count),
        .err_any   (err_any),
        .overrun   (overrun)
    );

    rxq_dmaready #(.DEPTH(DEPTH)) u_dma (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (count),
        .level   (level),
        .err_any (err_any),
        .tmo     (rx_tmo),
        .rdy     (blk_rdy)
    );

    assign nonempty   = (count != '0);
    assign rd_data    = nonempty ? head.data : 8'h00;
    assign status     = {err_any, 2'b00,
                         nonempty & head.brk, nonempty & head.frm, nonempty & head.par,
                         overrun, nonempty};
    assign trig_hit   = s_q.en && (count >= level);
    assign dma_rx_rdy = (s_q.en && dma_blk) ? blk_rdy : nonempty;

    AST_STATUS_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !hold_rd && !chr_vld && !clr |=> $stable(count) && $stable(rd_data)); // R5

    AST_EMPTY_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !nonempty |-> status[4:2] == 3'b000 && rd_data == 8'h00); // R3

endmodule

// File: tb/rx_char_queue_tb.sv
`timescale 1ns/1ps
module rx_char_queue_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       q_en = 1'b0, dma_blk = 1'b0, flush = 1'b0, rx_tmo = 1'b0;
    logic [1:0] trig_lvl = 2'd0;
    logic       chr_vld = 1'b0, chr_brk = 1'b0, chr_frm = 1'b0, chr_par = 1'b0;
    logic [7:0] chr_data = 8'h00;
    logic       hold_rd = 1'b0, stat_rd = 1'b0;
    logic [7:0] rd_data, status;
    logic       trig_hit, dma_rx_rdy;

    always #2 clk = ~clk;

    rx_char_queue dut_i (
        .clk(clk), .rst_n(rst_n), .q_en(q_en), .dma_blk(dma_blk),
        .trig_lvl(trig_lvl), .flush(flush), .rx_tmo(rx_tmo),
        .chr_vld(chr_vld), .chr_data(chr_data), .chr_brk(chr_brk),
        .chr_frm(chr_frm), .chr_par(chr_par), .hold_rd(hold_rd),
        .stat_rd(stat_rd), .rd_data(rd_data), .status(status),
        .trig_hit(trig_hit), .dma_rx_rdy(dma_rx_rdy)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    string phase = "reset";

    // reference model
    logic [10:0] mq[$];
    bit          m_ovr = 0, m_en = 0, m_rdy = 0;

    function automatic int lvl_of(input logic [1:0] s);
        case (s)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 56;
            default: return 60;
        endcase
    endfunction

    function automatic bit any_bad();
        foreach (mq[i]) if (mq[i][10:8] != 3'b000) return 1;
        return 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s [%s] at %0t: actual=%0h expected=%0h", req, phase, $time, act, exp);
        end
    endtask

    task automatic compare();
        int sz;
        sz = mq.size();
        chk("R1", int'(rd_data), sz != 0 ? int'(mq[0][7:0]) : 0);
        chk("R2", int'({status[6:5], status[0]}), sz != 0 ? 1 : 0);
        chk("R3", int'(status[4:2]), sz != 0 ? int'(mq[0][10:8]) : 0);
        chk("R4", int'(status[7]), int'(any_bad()));
        chk("R6", int'(status[1]), int'(m_ovr));
        chk("R9", int'(trig_hit), (m_en && sz >= lvl_of(trig_lvl)) ? 1 : 0);
        if (m_en && dma_blk) chk("R10", int'(dma_rx_rdy), int'(m_rdy));
        else                 chk("R11", int'(dma_rx_rdy), sz != 0 ? 1 : 0);
    endtask

    task automatic model_update();
        int sz;
        bit pop, clr, setov, nrdy;
        sz    = mq.size();
        nrdy  = (sz == 0 || any_bad()) ? 1'b0
              : ((sz >= lvl_of(trig_lvl) || rx_tmo) ? 1'b1 : m_rdy);
        pop   = hold_rd && sz != 0;
        clr   = flush || (q_en != m_en);
        setov = 0;
        if (clr) begin
            mq.delete();
        end else if (m_en) begin
            if (pop) void'(mq.pop_front());
            if (chr_vld) begin
                if (mq.size() < 64) mq.push_back({chr_brk, chr_frm, chr_par, chr_data});
                else setov = 1;
            end
        end else begin
            if (chr_vld) begin
                if (sz == 1 && !pop) setov = 1;
                mq.delete();
                mq.push_back({chr_brk, chr_frm, chr_par, chr_data});
            end else if (pop) begin
                mq.delete();
            end
        end
        if (setov)        m_ovr = 1;
        else if (stat_rd) m_ovr = 0;
        m_en  = q_en;
        m_rdy = nrdy;
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic cyc(input bit wv, input logic [10:0] w, input bit rd, input bit st);
        chr_vld = wv;
        {chr_brk, chr_frm, chr_par, chr_data} = w;
        hold_rd = rd;
        stat_rd = st;
        step();
        chr_vld = 0; hold_rd = 0; stat_rd = 0;
        {chr_brk, chr_frm, chr_par, chr_data} = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog [%s]: actual=expired expected=finished", phase);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R2 reset state";
        compare();

        phase = "enable R8 mode change";
        q_en = 1;
        step();

        phase = "R3 mixed flags incl break 0x00";
        cyc(1, {3'b000, 8'h41}, 0, 0);
        cyc(1, {3'b100, 8'h00}, 0, 0);
        cyc(1, {3'b010, 8'h7e}, 0, 0);
        cyc(1, {3'b001, 8'h99}, 0, 0);
        cyc(1, {3'b000, 8'h5a}, 0, 0);
        phase = "R5 status reads do not pop";
        repeat (3) cyc(0, '0, 0, 1);
        phase = "R4 drain until clean";
        repeat (6) cyc(0, '0, 1, 0);
        phase = "R1 pop on empty ignored";
        cyc(0, '0, 1, 1);

        phase = "R6 fill to 64 and overflow";
        for (int i = 0; i < 64; i++) cyc(1, {3'(i % 5 == 0 ? 3'b010 : 3'b000), 8'(i + 3)}, 0, 0);
        for (int t = 0; t < 4; t++) begin
            trig_lvl = 2'(t);
            step();
        end
        cyc(1, {3'b000, 8'hee}, 0, 0);
        cyc(1, {3'b100, 8'hef}, 0, 1);
        cyc(0, '0, 0, 1);
        cyc(1, {3'b000, 8'hc3}, 1, 0);
        phase = "R9 drain across levels";
        trig_lvl = 2'd2;
        repeat (10) cyc(0, '0, 1, 0);
        trig_lvl = 2'd1;
        repeat (45) cyc(0, '0, 1, 0);

        phase = "R8 flush keeps overrun";
        cyc(1, {3'b000, 8'h11}, 0, 0);
        cyc(1, {3'b001, 8'h12}, 0, 0);
        for (int i = 0; i < 64; i++) cyc(1, {3'b000, 8'(i)}, 0, 0);
        flush = 1;
        cyc(1, {3'b010, 8'h13}, 0, 0);
        flush = 0;
        cyc(0, '0, 0, 1);

        phase = "R10 block dma";
        dma_blk = 1;
        trig_lvl = 2'd0;
        for (int i = 0; i < 9; i++) cyc(1, {3'b000, 8'(8'h20 + i)}, 0, 0);
        repeat (6) cyc(0, '0, 1, 0);
        repeat (4) cyc(0, '0, 1, 0);
        cyc(1, {3'b000, 8'h30}, 0, 0);
        rx_tmo = 1; step(); rx_tmo = 0;
        step();
        cyc(1, {3'b001, 8'h31}, 0, 0);
        repeat (3) step();
        repeat (2) cyc(0, '0, 1, 0);
        step();

        phase = "R7 R11 disabled single slot";
        dma_blk = 0;
        q_en = 0;
        step();
        cyc(1, {3'b000, 8'h61}, 0, 0);
        cyc(1, {3'b010, 8'h62}, 0, 0);
        cyc(0, '0, 0, 1);
        cyc(1, {3'b000, 8'h63}, 1, 0);
        cyc(0, '0, 1, 0);
        cyc(1, {3'b100, 8'h00}, 0, 0);
        dma_blk = 1;
        step();
        cyc(0, '0, 1, 0);

        phase = "R1 R6 R10 random traffic";
        q_en = 1;
        for (int blk = 0; blk < 8; blk++) begin
            dma_blk  = blk[0];
            trig_lvl = 2'(blk >> 1);
            for (int i = 0; i < 600; i++) begin
                int r;
                r = $urandom_range(99);
                chr_vld  = (r < ((blk % 3 == 0) ? 75 : 50));
                chr_data = 8'($urandom);
                chr_brk  = ($urandom_range(15) == 0);
                chr_frm  = ($urandom_range(15) == 0);
                chr_par  = ($urandom_range(15) == 0);
                hold_rd  = ($urandom_range(99) < ((blk % 3 == 0) ? 25 : 45));
                stat_rd  = ($urandom_range(9) == 0);
                rx_tmo   = ($urandom_range(15) == 0);
                flush    = ($urandom_range(299) == 0);
                if ($urandom_range(399) == 0) q_en = ~q_en;
                step();
            end
        end
        chr_vld = 0; hold_rd = 0; stat_rd = 0; rx_tmo = 0; flush = 0;
        step();

        summary();
        $finish;
    end

endmodule